// File: doc/BRIEF.md
# Two-Level Page-Table Address Translator

This block turns 32-bit virtual addresses, issued by an internal processor or a DMA client, into physical addresses. Pages are 4 KiB. The tables live in system memory and are kept up to date by software. Software first writes the physical base of the top-level table into a register. It then raises the translation enable. After that, each request either hits in a small fully associative translation cache or starts a walk. A walk makes two dependent table reads through a memory read port. The first read uses VA[31:22] to select a top-level entry. The second read uses VA[21:12] to select a leaf entry. VA[11:0] passes through unchanged as the page offset.

A table entry is 32 bits. Bit 0 marks it valid and bits [31:12] hold a page frame number. For a top-level entry, that frame is the base of the leaf table. A clear valid bit at either level produces a fault response, and the faulting virtual address is latched. Software issues a whole-cache invalidate after each unmap or free. If the invalidate lands while a walk is in flight, the walk still answers, but its result is not cached.

The walk sequencer uses five states. IDLE accepts requests. On a miss, IDLE goes to L1_ISSUE. L1_ISSUE holds the top-level read and moves to L1_WAIT once the memory port takes it. From L1_WAIT, returned data with a clear valid bit goes back to IDLE with a fault, and a valid entry goes to L2_ISSUE. L2_ISSUE moves to L2_WAIT when the leaf read is taken. L2_WAIT returns to IDLE on the leaf data, either with a translation or with a fault.

Top module: `pt_mmu`

## Requirements
- R1: After reset, rsp_valid, mem_req_valid and rsp_fault are 0, fault_va is 0, and every cache entry is empty.
- R2: req_ready is 1 only while xlate_en is 1 and no walk is in progress. While xlate_en is 0, no request is accepted, no table read is issued and no response is produced.
- R3: On a miss, the first read goes to cfg base + VA[31:22]*4. The second read goes to {L1[31:12], 12'h000} + VA[21:12]*4. Each read address is held stable while mem_req_ready is 0.
- R4: When the leaf entry has bit 0 set, the response gives rsp_pa = {L2[31:12], VA[11:0]} with rsp_fault = 0, in the cycle after the leaf data arrives.
- R5: For a request to a cached page, rsp_valid is 1 in the cycle after acceptance, with the cached frame and the request's offset, and no table read is made.
- R6: A top-level or leaf entry with bit 0 clear gives rsp_fault = 1 and rsp_pa = 0, and latches the request's VA into fault_va. A top-level fault makes only one read. Nothing is cached, so a repeat request walks again.
- R7: The cache holds 8 pages and refills slots in round-robin order. The ninth distinct page evicts the first page filled.
- R8: inv_req empties the whole cache. A request accepted in the same cycle as inv_req is treated as a miss, and no fill happens in a cycle where inv_req is 1.
- R9: An invalidate that arrives during a walk does not stop the walk's response, but its translation is not cached.
- R10: While a table read is pending, req_ready stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xlate_en | input | 1 | Translation enable |
| cfg_base_we | input | 1 | Write strobe for the top-level table base |
| cfg_base_pa | input | 32 | Physical base of the top-level table |
| inv_req | input | 1 | Whole-cache invalidate pulse |
| req_valid | input | 1 | Translation request valid |
| req_va | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_pa | output | 32 | Translated physical address (0 on fault) |
| rsp_fault | output | 1 | Response is a fault |
| fault_va | output | 32 | Virtual address of the latest fault |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory port takes the read |
| mem_req_addr | output | 32 | Table entry address |
| mem_rsp_valid | input | 1 | Table read data valid |
| mem_rsp_data | input | 32 | Table entry returned |

## Verification
The assertions make three assumptions about the environment. The memory port answers each accepted read exactly once, and only while a read is outstanding. The table base is not rewritten during a walk. The requester takes every response strobe, because rsp_valid has no backpressure. The bench meets these assumptions in the following way. Its memory model returns one word on the cycle after each handshake and stalls mem_req_ready on a fixed pattern. It writes the base only before enabling translation. It issues one request at a time and waits for that request's response before sending the next. Invalidates are placed either on the acceptance cycle or a few cycles into a miss walk, so they always fall on a known phase.

// File: rtl/pt_mmu_pkg.sv
package pt_mmu_pkg;

    localparam int VA_W  = 32;
    localparam int PA_W  = 32;
    localparam int OFF_W = 12;
    localparam int IDX_W = 10;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PFN_W = PA_W - OFF_W;
    localparam int PTE_V = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_ISSUE,
        ST_L1_WAIT,
        ST_L2_ISSUE,
        ST_L2_WAIT
    } walk_state_e;

    // Address of a 4-byte entry inside a table.
    function automatic logic [PA_W-1:0] entry_addr(input logic [PA_W-1:0] tbl,
                                                   input logic [IDX_W-1:0] idx);
        return tbl + {{(PA_W-IDX_W-2){1'b0}}, idx, 2'b00};
    endfunction

endpackage

// File: rtl/pt_mmu_tlb.sv
module pt_mmu_tlb
    import pt_mmu_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lookup_vpn,
    output logic             hit,
    output logic [PFN_W-1:0] hit_pfn,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             inv
);

    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic             vld_q [ENTRIES];
    logic [VPN_W-1:0] vpn_q [ENTRIES];
    logic [PFN_W-1:0] pfn_q [ENTRIES];
    logic [ENTRIES-1:0] match;
    logic [PTR_W-1:0] ptr_q;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = vld_q[g] && (vpn_q[g] == lookup_vpn);
    end

    assign hit = |match;

    always_comb begin
        hit_pfn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) hit_pfn = hit_pfn | pfn_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                vld_q[i] <= 1'b0;
                vpn_q[i] <= '0;
                pfn_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (inv) begin
                    vld_q[i] <= 1'b0;
                end else if (fill_en && (ptr_q == PTR_W'(i))) begin
                    vld_q[i] <= 1'b1;
                    vpn_q[i] <= fill_vpn;
                    pfn_q[i] <= fill_pfn;
                end
            end
        end
    end

    // Round-robin victim pointer; advances on each fill only.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (fill_en && !inv) begin
            ptr_q <= (ptr_q == PTR_W'(ENTRIES-1)) ? '0 : ptr_q + 1'b1;
        end
    end

endmodule

// File: rtl/pt_mmu_walker.sv
module pt_mmu_walker
    import pt_mmu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xlate_en,
    input  logic [PA_W-1:0]  l1_base,
    input  logic             inv,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_va,
    output logic             req_ready,
    input  logic             tlb_hit,
    input  logic [PFN_W-1:0] tlb_pfn,
    output logic             fill_en,
    output logic [VPN_W-1:0] fill_vpn,
    output logic [PFN_W-1:0] fill_pfn,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [31:0]      mem_rsp_data,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_pa,
    output logic             rsp_fault,
    output logic [VA_W-1:0]  fault_va
);

    walk_state_e      state_q, state_d;
    logic [VA_W-1:0]  va_q;
    logic [PFN_W-1:0] l1_pfn_q;
    logic             drop_q;
    logic             rsp_valid_q, rsp_fault_q;
    logic [PA_W-1:0]  rsp_pa_q;
    logic [VA_W-1:0]  fault_va_q;

    logic accept, hit_eff, pte_ok;
    logic unused_pte_bits;

    assign accept          = req_valid && req_ready;
    assign hit_eff         = tlb_hit && !inv;
    assign pte_ok          = mem_rsp_data[PTE_V];
    assign unused_pte_bits = ^mem_rsp_data[OFF_W-1:1];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (accept && !hit_eff) state_d = ST_L1_ISSUE;
            ST_L1_ISSUE: if (mem_req_ready)      state_d = ST_L1_WAIT;
            ST_L1_WAIT:  if (mem_rsp_valid)      state_d = pte_ok ? ST_L2_ISSUE : ST_IDLE;
            ST_L2_ISSUE: if (mem_req_ready)      state_d = ST_L2_WAIT;
            ST_L2_WAIT:  if (mem_rsp_valid)      state_d = ST_IDLE;
            default:                             state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        req_ready     = (state_q == ST_IDLE) && xlate_en;
        mem_req_valid = (state_q == ST_L1_ISSUE) || (state_q == ST_L2_ISSUE);
        mem_req_addr  = (state_q == ST_L1_ISSUE)
                      ? entry_addr(l1_base, va_q[VA_W-1:VA_W-IDX_W])
                      : entry_addr({l1_pfn_q, {OFF_W{1'b0}}}, va_q[OFF_W+IDX_W-1:OFF_W]);
        fill_en       = (state_q == ST_L2_WAIT) && mem_rsp_valid && pte_ok && !drop_q && !inv;
        fill_vpn      = va_q[VA_W-1:OFF_W];
        fill_pfn      = mem_rsp_data[PA_W-1:OFF_W];
    end

    // Walk context and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q        <= '0;
            l1_pfn_q    <= '0;
            drop_q      <= 1'b0;
            rsp_valid_q <= 1'b0;
            rsp_fault_q <= 1'b0;
            rsp_pa_q    <= '0;
            fault_va_q  <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            if (inv && state_q != ST_IDLE) drop_q <= 1'b1;
            if (accept) begin
                va_q   <= req_va;
                drop_q <= 1'b0;
                if (hit_eff) begin
                    rsp_valid_q <= 1'b1;
                    rsp_fault_q <= 1'b0;
                    rsp_pa_q    <= {tlb_pfn, req_va[OFF_W-1:0]};
                end
            end
            if (state_q == ST_L1_WAIT && mem_rsp_valid) begin
                if (pte_ok) begin
                    l1_pfn_q <= mem_rsp_data[PA_W-1:OFF_W];
                end else begin
                    rsp_valid_q <= 1'b1;
                    rsp_fault_q <= 1'b1;
                    rsp_pa_q    <= '0;
                    fault_va_q  <= va_q;
                end
            end
            if (state_q == ST_L2_WAIT && mem_rsp_valid) begin
                rsp_valid_q <= 1'b1;
                if (pte_ok) begin
                    rsp_fault_q <= 1'b0;
                    rsp_pa_q    <= {mem_rsp_data[PA_W-1:OFF_W], va_q[OFF_W-1:0]};
                end else begin
                    rsp_fault_q <= 1'b1;
                    rsp_pa_q    <= '0;
                    fault_va_q  <= va_q;
                end
            end
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_fault = rsp_fault_q;
    assign rsp_pa    = rsp_pa_q;
    assign fault_va  = fault_va_q;

endmodule

// File: rtl/pt_mmu.sv
module pt_mmu
    import pt_mmu_pkg::*;
#(
    parameter int TLB_ENTRIES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        xlate_en,
    input  logic        cfg_base_we,
    input  logic [31:0] cfg_base_pa,
    input  logic        inv_req,
    input  logic        req_valid,
    input  logic [31:0] req_va,
    output logic        req_ready,
    output logic        rsp_valid,
    output logic [31:0] rsp_pa,
    output logic        rsp_fault,
    output logic [31:0] fault_va,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic [31:0] mem_req_addr,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data
);

    logic [PA_W-1:0]  l1_base_q;
    logic             tlb_hit;
    logic [PFN_W-1:0] tlb_pfn;
    logic             fill_en;
    logic [VPN_W-1:0] fill_vpn;
    logic [PFN_W-1:0] fill_pfn;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           l1_base_q <= '0;
        else if (cfg_base_we) l1_base_q <= cfg_base_pa;
    end

    pt_mmu_tlb #(.ENTRIES(TLB_ENTRIES)) u_tlb (
        .clk        (clk),
        .rst_n      (rst_n),
        .lookup_vpn (req_va[VA_W-1:OFF_W]),
        .hit        (tlb_hit),
        .hit_pfn    (tlb_pfn),
        .fill_en    (fill_en),
        .fill_vpn   (fill_vpn),
        .fill_pfn   (fill_pfn),
        .inv        (inv_req)
    );

    pt_mmu_walker u_walker (
        .clk           (clk),
        .rst_n         (rst_n),
        .xlate_en      (xlate_en),
        .l1_base       (l1_base_q),
        .inv           (inv_req),
        .req_valid     (req_valid),
        .req_va        (req_va),
        .req_ready     (req_ready),
        .tlb_hit       (tlb_hit),
        .tlb_pfn       (tlb_pfn),
        .fill_en       (fill_en),
        .fill_vpn      (fill_vpn),
        .fill_pfn      (fill_pfn),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .rsp_valid     (rsp_valid),
        .rsp_pa        (rsp_pa),
        .rsp_fault     (rsp_fault),
        .fault_va      (fault_va)
    );

endmodule

// File: rtl/pt_mmu_checker.sv
module pt_mmu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        xlate_en,
    input logic        inv_req,
    input logic        req_valid,
    input logic        req_ready,
    input logic        tlb_hit,
    input logic        fill_en,
    input logic        rsp_valid,
    input logic        rsp_fault,
    input logic [31:0] rsp_pa,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_req_addr
);

    assert_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !xlate_en |-> !req_ready);

    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_hit_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && tlb_hit && !inv_req) |=> (rsp_valid && !rsp_fault));

    assert_fault_zero_pa_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_pa == 32'h0));

    assert_no_fill_on_inv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |-> !inv_req);

    assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

endmodule

bind pt_mmu pt_mmu_checker u_pt_mmu_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .xlate_en      (xlate_en),
    .inv_req       (inv_req),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .tlb_hit       (tlb_hit),
    .fill_en       (fill_en),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .rsp_pa        (rsp_pa),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/pt_mmu_bench.sv
module pt_mmu_bench;

    localparam logic [31:0] BASE = 32'h0010_0000;
    localparam logic [19:0] TBL0 = 20'h00200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlate_en = 1'b0;
    logic        cfg_base_we = 1'b0;
    logic [31:0] cfg_base_pa = '0;
    logic        inv_req = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [31:0] rsp_pa;
    logic        rsp_fault;
    logic [31:0] fault_va;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    pt_mmu u_pt_mmu (.*);

    // Behavioural memory and reference state
    logic [31:0] mem_m [logic [31:0]];
    logic [31:0] rd_q [$];
    int          next_tbl = 0;
    bit          m_v   [8];
    logic [19:0] m_vpn [8];
    logic [19:0] m_pfn [8];
    int          m_ptr = 0;
    bit          pend = 1'b0;
    logic [31:0] pend_addr = '0;
    int          stall = 0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem_m.exists(a) ? mem_m[a] : 32'h0;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic void map_page(input logic [19:0] vpn, input logic [19:0] pfn, input bit leaf_ok);
        logic [31:0] l1a;
        logic [19:0] tpfn;
        l1a = BASE + {20'h0, vpn[19:10], 2'b00};
        if (!mem_m.exists(l1a)) begin
            tpfn = TBL0 + 20'(next_tbl);
            next_tbl++;
            mem_m[l1a] = {tpfn, 11'h0, 1'b1};
        end
        tpfn = mem_m[l1a][31:12];
        mem_m[{tpfn, 12'h0} + {20'h0, vpn[9:0], 2'b00}] = {pfn, 11'h0, leaf_ok};
    endfunction

    // Memory port: one word back on the cycle after each handshake
    always @(negedge clk) begin
        if (pend) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = rd(pend_addr);
            pend = 1'b0;
        end else begin
            mem_rsp_valid = 1'b0;
        end
        stall++;
        mem_req_ready = (stall % 3) != 0;
        if (rst_n && mem_req_valid && mem_req_ready) begin
            pend = 1'b1;
            pend_addr = mem_req_addr;
            rd_q.push_back(mem_req_addr);
        end
    end

    // inv_at: -1 none, 0 on the acceptance cycle, k>0 k cycles after acceptance
    task automatic send(input logic [31:0] va, input int inv_at, input string tag);
        bit          exp_hit, exp_fault, exp_fill;
        logic [31:0] exp_pa, l1, l2;
        logic [31:0] exp_addr [$];
        int          r0, lat;
        bit          seen;
        exp_hit = 1'b0; exp_pa = '0; exp_fault = 1'b0; exp_fill = 1'b0;
        if (inv_at == 0) for (int i = 0; i < 8; i++) m_v[i] = 1'b0;
        for (int i = 0; i < 8; i++)
            if (m_v[i] && m_vpn[i] == va[31:12]) begin exp_hit = 1'b1; exp_pa = {m_pfn[i], va[11:0]}; end
        if (!exp_hit) begin
            exp_addr.push_back(BASE + {20'h0, va[31:22], 2'b00});
            l1 = rd(exp_addr[0]);
            if (!l1[0]) exp_fault = 1'b1;
            else begin
                exp_addr.push_back({l1[31:12], 12'h0} + {20'h0, va[21:12], 2'b00});
                l2 = rd(exp_addr[1]);
                if (!l2[0]) exp_fault = 1'b1;
                else begin exp_pa = {l2[31:12], va[11:0]}; exp_fill = (inv_at <= 0); end
            end
        end
        @(negedge clk); #1;
        req_valid = 1'b1; req_va = va;
        if (inv_at == 0) inv_req = 1'b1;
        while (!req_ready) begin @(negedge clk); #1; end
        r0 = rd_q.size();
        seen = 1'b0; lat = 0;
        for (int c = 1; c <= 60 && !seen; c++) begin
            @(negedge clk); #1;
            req_valid = 1'b0;
            inv_req = (inv_at > 0 && c == inv_at);
            if (rsp_valid) begin seen = 1'b1; lat = c; end
            else if (c == 1) chk(!req_ready, "R10", "req_ready during walk", 32'(req_ready), 32'h0);
        end
        inv_req = 1'b0;
        chk(seen, tag, "response seen", 32'(seen), 32'h1);
        chk(rsp_fault == exp_fault, tag, "rsp_fault", 32'(rsp_fault), 32'(exp_fault));
        chk(rsp_pa == exp_pa, tag, "rsp_pa", rsp_pa, exp_pa);
        chk(rd_q.size() - r0 == exp_addr.size(), tag, "table reads", 32'(rd_q.size() - r0), 32'(exp_addr.size()));
        for (int i = 0; i < exp_addr.size() && r0 + i < rd_q.size(); i++)
            chk(rd_q[r0+i] == exp_addr[i], "R3", "table read address", rd_q[r0+i], exp_addr[i]);
        if (exp_hit) chk(lat == 1, "R5", "hit latency", 32'(lat), 32'h1);
        if (exp_fault) chk(fault_va == va, "R6", "fault_va", fault_va, va);
        if (inv_at > 0) for (int i = 0; i < 8; i++) m_v[i] = 1'b0;
        if (exp_fill) begin
            m_v[m_ptr] = 1'b1; m_vpn[m_ptr] = va[31:12]; m_pfn[m_ptr] = exp_pa[31:12];
            m_ptr = (m_ptr + 1) % 8;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int r0;
        for (int i = 0; i < 8; i++) map_page(20'h00400 + 20'(i), 20'h5A000 + 20'(i), 1'b1);
        map_page(20'h80000, 20'h6B000, 1'b1);
        map_page(20'h80010, 20'h6B001, 1'b1);
        map_page(20'h0040F, 20'h00000, 1'b0);

        repeat (3) @(negedge clk);
        #1;
        chk(!rsp_valid, "R1", "rsp_valid in reset", 32'(rsp_valid), 0);
        chk(!mem_req_valid, "R1", "mem_req_valid in reset", 32'(mem_req_valid), 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(fault_va == 0, "R1", "fault_va after reset", fault_va, 0);
        chk(!rsp_fault, "R1", "rsp_fault after reset", 32'(rsp_fault), 0);
        chk(!req_ready, "R2", "req_ready while disabled", 32'(req_ready), 0);

        // R2: disabled block ignores a held request
        r0 = rd_q.size();
        req_valid = 1'b1; req_va = 32'h0040_0123;
        for (int c = 0; c < 5; c++) begin
            @(negedge clk); #1;
            chk(!rsp_valid && !req_ready, "R2", "no response while disabled", 32'(rsp_valid), 0);
        end
        chk(rd_q.size() == r0, "R2", "no reads while disabled", 32'(rd_q.size() - r0), 0);
        req_valid = 1'b0;
        cfg_base_pa = BASE; cfg_base_we = 1'b1;
        @(negedge clk); #1;
        cfg_base_we = 1'b0; xlate_en = 1'b1;
        @(negedge clk); #1;

        send(32'h0040_0ABC, -1, "R4");   // cold cache: walk
        send(32'h0040_0123, -1, "R5");   // same page hits
        send(32'h4000_0010, -1, "R6");   // top-level fault
        send(32'h0040_F008, -1, "R6");   // leaf fault
        send(32'h0040_F00C, -1, "R6");   // not cached: walks again
        for (int i = 1; i < 8; i++) send(32'h0040_1000 * 0 + {20'h00400 + 20'(i), 12'h044}, -1, "R7");
        send(32'h8000_0777, -1, "R7");   // ninth page evicts first
        send(32'h0040_0ABC, -1, "R7");   // first page must walk again
        send(32'h0040_3000, -1, "R7");   // still cached
        // R8: standalone invalidate
        @(negedge clk); #1; inv_req = 1'b1;
        @(negedge clk); #1; inv_req = 1'b0;
        for (int i = 0; i < 8; i++) m_v[i] = 1'b0;
        send(32'h0040_3010, -1, "R8");   // walks after invalidate
        send(32'h0040_3020, 0, "R8");    // invalidate on accept: miss
        send(32'h0040_3030, -1, "R8");
        send(32'h8001_0004, 2, "R9");    // invalidate mid-walk
        send(32'h8001_0008, -1, "R9");   // result was not kept
        send(32'h8001_000C, -1, "R9");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule